// File: doc/BRIEF.md
# Zero-Pattern Prefix Encoder

This block sits in the write path of a byte-organised memory. It takes one 64-bit write word, split into eight bytes, and sorts it into one of four classes by where the zero bytes are. Three classes cover common zero-extended values, and the fourth class is raw data. For each word the block emits a 2-bit prefix that names the class. It also emits a compacted payload, left-justified in a 64-bit field, and a length field set to 0, 32 or 64 bits. A scheduler downstream can use the prefix to skip all-zero words and to pair two half-size words inside one power budget.

The block also produces the word rearranged onto four 16-bit chip lanes. Chip lane i carries byte (7-i) in its upper half and byte i in its lower half. This mapping gives every chip the same number of possibly non-zero bytes for both compressible half-word patterns. Words enter on a valid/ready handshake and leave on a valid/ready handshake, two register stages later. A stalled output holds its values.

Top module: `zpe_encoder`

## Requirements
- R1: A byte is treated as non-zero when any one of its eight bits is 1. A single set bit anywhere in a byte makes that byte count as non-zero.
- R2: A word whose eight bytes are all zero gets prefix 2'b00, length 0, an all-zero payload and all-zero lanes.
- R3: A word whose bytes 7..4 are zero (and which is not all zero) gets prefix 2'b01. The payload carries word[31:0] in payload[63:32] and zeros in payload[31:0], and the length is 32.
- R4: A word whose bytes 7, 6, 3 and 2 are zero, and which matches neither R2 nor R3, gets prefix 2'b10. The payload carries {byte5, byte4, byte1, byte0} in payload[63:32] and zeros below, and the length is 32.
- R5: Every other word gets prefix 2'b11. The payload is the unchanged word and the length is 64.
- R6: When more than one pattern matches, the all-zero pattern wins first, then 2'b01, then 2'b10. For example, a word with only bytes 1..0 non-zero gets 2'b01.
- R7: out_lanes[16i+15:16i] = {byte(7-i), byte(i)} of the input word for i = 0..3, for every prefix.
- R8: A word accepted on a clock edge appears on the outputs after the following edge, so the result takes two register stages. Words leave in the order they entered, each exactly once. With out_ready held high, one word can be accepted on every clock.
- R9: While out_valid is high and out_ready is low, every output holds its value. While that stall lasts with the first stage full, in_ready is low and in_word is not taken.
- R10: After reset, out_valid is low. While out_ready is high and the pipeline is empty, in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_word | input | 64 | Write word, byte 0 in bits 7:0 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_prefix | output | 2 | Pattern class (00, 01, 10, 11) |
| out_payload | output | 64 | Compacted data, left-justified |
| out_len | output | 7 | Payload length in bits: 0, 32 or 64 |
| out_lanes | output | 64 | Four 16-bit chip lanes, lane 0 in bits 15:0 |

## Verification
The hard case is a new word arriving on the same edge that the output stage is stalled or drains. In that case the first stage must either keep its word or hand it on while it takes the next one, and no word may be lost or sent twice. The bench provokes this by sending a long run of words back to back while out_ready toggles pseudo-randomly. Every word that leaves is checked in order against a queue of expected values. Outputs that are held under a stall are also checked from one cycle to the next to confirm they did not change.

// File: rtl/zpe_pkg.sv
package zpe_pkg;

  typedef enum logic [1:0] {
    PFX_ZERO = 2'b00,
    PFX_LOW  = 2'b01,
    PFX_PAIR = 2'b10,
    PFX_RAW  = 2'b11
  } zpe_prefix_e;

endpackage

// File: rtl/zpe_zero_detect.sv
module zpe_zero_detect #(
  parameter int NBYTES = 8,
  parameter int BYTE_W = 8,
  localparam int W = NBYTES * BYTE_W
) (
  input  logic [W-1:0]      word,
  output logic [NBYTES-1:0] nz
);

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign nz[b] = |word[b*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/zpe_classify.sv
module zpe_classify #(
  parameter int NBYTES = 8
) (
  input  logic [NBYTES-1:0]  nz,
  output zpe_pkg::zpe_prefix_e prefix
);
  import zpe_pkg::*;

  // Bytes that must be zero for the half-word pattern.
  function automatic logic [NBYTES-1:0] f_hi_mask();
    logic [NBYTES-1:0] m;
    for (int b = 0; b < NBYTES; b++) m[b] = (b >= NBYTES / 2);
    return m;
  endfunction

  // Bytes that must be zero for the alternating-pair pattern.
  function automatic logic [NBYTES-1:0] f_pair_mask();
    logic [NBYTES-1:0] m;
    for (int b = 0; b < NBYTES; b++) m[b] = ((b % 4) >= 2);
    return m;
  endfunction

  localparam logic [NBYTES-1:0] HI_MASK   = f_hi_mask();
  localparam logic [NBYTES-1:0] PAIR_MASK = f_pair_mask();

  always_comb begin
    if (nz == '0)                        prefix = PFX_ZERO;
    else if ((nz & HI_MASK) == '0)       prefix = PFX_LOW;
    else if ((nz & PAIR_MASK) == '0)     prefix = PFX_PAIR;
    else                                 prefix = PFX_RAW;
  end

endmodule

// File: rtl/zpe_pack.sv
module zpe_pack #(
  parameter int NBYTES = 8,
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 7,
  localparam int W  = NBYTES * BYTE_W,
  localparam int H  = NBYTES / 2,
  localparam int HW = H * BYTE_W
) (
  input  logic [W-1:0]         word,
  input  zpe_pkg::zpe_prefix_e prefix,
  output logic [W-1:0]         payload,
  output logic [LEN_W-1:0]     len
);
  import zpe_pkg::*;

  logic [HW-1:0] pair_pack;

  // Kept bytes of the pair pattern: source byte 4*(k/2) + k%2.
  for (genvar k = 0; k < H; k++) begin : g_pair
    assign pair_pack[k*BYTE_W +: BYTE_W] = word[((k / 2) * 4 + (k % 2))*BYTE_W +: BYTE_W];
  end

  always_comb begin
    unique case (prefix)
      PFX_ZERO: begin
        payload = '0;
        len     = '0;
      end
      PFX_LOW: begin
        payload = {word[HW-1:0], {HW{1'b0}}};
        len     = LEN_W'(HW);
      end
      PFX_PAIR: begin
        payload = {pair_pack, {HW{1'b0}}};
        len     = LEN_W'(HW);
      end
      default: begin
        payload = word;
        len     = LEN_W'(W);
      end
    endcase
  end

endmodule

// File: rtl/zpe_lane_map.sv
module zpe_lane_map #(
  parameter int NBYTES = 8,
  parameter int BYTE_W = 8,
  localparam int W = NBYTES * BYTE_W
) (
  input  logic [W-1:0] word,
  output logic [W-1:0] lanes
);

  localparam int LANE_W = 2 * BYTE_W;

  for (genvar i = 0; i < NBYTES / 2; i++) begin : g_lane
    assign lanes[i*LANE_W +: LANE_W] = {word[(NBYTES-1-i)*BYTE_W +: BYTE_W],
                                        word[i*BYTE_W +: BYTE_W]};
  end

endmodule

// File: rtl/zpe_encoder.sv
module zpe_encoder #(
  parameter int NBYTES = 8,
  parameter int BYTE_W = 8,
  localparam int W     = NBYTES * BYTE_W,
  localparam int LEN_W = $clog2(W) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_word,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_prefix,
  output logic [W-1:0]     out_payload,
  output logic [LEN_W-1:0] out_len,
  output logic [W-1:0]     out_lanes
);
  import zpe_pkg::*;

  // Stage 1: word and per-byte non-zero flags
  logic              s1_v, s1_v_d;
  logic [W-1:0]      s1_word;
  logic [NBYTES-1:0] s1_nz;
  logic [NBYTES-1:0] nz_c;

  // Stage 2: classified result
  logic              s2_v, s2_v_d;
  logic [1:0]        s2_prefix;
  logic [W-1:0]      s2_payload;
  logic [LEN_W-1:0]  s2_len;
  logic [W-1:0]      s2_lanes;

  logic              s1_en, s2_en, s1_load, s2_load;
  zpe_prefix_e       prefix_c;
  logic [W-1:0]      payload_c, lanes_c;
  logic [LEN_W-1:0]  len_c;

  zpe_zero_detect #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_zero (
    .word (in_word),
    .nz   (nz_c)
  );

  zpe_classify #(.NBYTES(NBYTES)) u_class (
    .nz     (s1_nz),
    .prefix (prefix_c)
  );

  zpe_pack #(.NBYTES(NBYTES), .BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_pack (
    .word    (s1_word),
    .prefix  (prefix_c),
    .payload (payload_c),
    .len     (len_c)
  );

  zpe_lane_map #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_lanes (
    .word  (s1_word),
    .lanes (lanes_c)
  );

  // Next-state logic
  always_comb begin
    s2_en   = !s2_v || out_ready;
    s1_en   = !s1_v || s2_en;
    s1_load = s1_en && in_valid;
    s2_load = s2_en && s1_v;
    s1_v_d  = s1_en ? in_valid : s1_v;
    s2_v_d  = s2_en ? s1_v     : s2_v;
  end

  // Valid registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else begin
      s1_v <= s1_v_d;
      s2_v <= s2_v_d;
    end
  end

  // Stage 1 data registers
  always_ff @(posedge clk) begin
    if (s1_load) begin
      s1_word <= in_word;
      s1_nz   <= nz_c;
    end
  end

  // Stage 2 data registers
  always_ff @(posedge clk) begin
    if (s2_load) begin
      s2_prefix  <= prefix_c;
      s2_payload <= payload_c;
      s2_len     <= len_c;
      s2_lanes   <= lanes_c;
    end
  end

  assign in_ready    = s1_en;
  assign out_valid   = s2_v;
  assign out_prefix  = s2_prefix;
  assign out_payload = s2_payload;
  assign out_len     = s2_len;
  assign out_lanes   = s2_lanes;

endmodule

// File: rtl/zpe_encoder_chk.sv
module zpe_encoder_chk #(
  parameter int NBYTES = 8,
  parameter int BYTE_W = 8,
  localparam int W     = NBYTES * BYTE_W,
  localparam int LEN_W = $clog2(W) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [1:0]       out_prefix,
  input logic [W-1:0]     out_payload,
  input logic [LEN_W-1:0] out_len,
  input logic [W-1:0]     out_lanes
);

  localparam int HW = W / 2;

  logic hi_lanes_zero;
  logic raw_lanes_ok;

  always_comb begin
    hi_lanes_zero = 1'b1;
    raw_lanes_ok  = 1'b1;
    for (int i = 0; i < NBYTES / 2; i++) begin
      if (out_lanes[(2*i+1)*BYTE_W +: BYTE_W] != '0) hi_lanes_zero = 1'b0;
      if (out_lanes[2*i*BYTE_W +: 2*BYTE_W] !=
          {out_payload[(NBYTES-1-i)*BYTE_W +: BYTE_W], out_payload[i*BYTE_W +: BYTE_W]})
        raw_lanes_ok = 1'b0;
    end
  end

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_prefix) && $stable(out_payload)
                                && $stable(out_len) && $stable(out_lanes));

  assert_stall_blocks_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid && !out_ready);

  assert_zero_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_prefix == 2'b00 |-> out_len == '0 && out_payload == '0 && out_lanes == '0);

  assert_half_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_prefix == 2'b01 || out_prefix == 2'b10)
      |-> out_len == LEN_W'(HW) && out_payload[HW-1:0] == '0);

  assert_low_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_prefix == 2'b01 |-> hi_lanes_zero);

  assert_raw_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_prefix == 2'b11 |-> out_len == LEN_W'(W));

  assert_raw_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_prefix == 2'b11 |-> raw_lanes_ok);

endmodule

bind zpe_encoder zpe_encoder_chk #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_prefix  (out_prefix),
  .out_payload (out_payload),
  .out_len     (out_len),
  .out_lanes   (out_lanes)
);

// File: tb/zpe_encoder_tb_top.sv
`timescale 1ns/1ps
module zpe_encoder_tb_top;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_word;
  logic        out_valid;
  logic        out_ready;
  logic [1:0]  out_prefix;
  logic [63:0] out_payload;
  logic [6:0]  out_len;
  logic [63:0] out_lanes;

  zpe_encoder dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_prefix(out_prefix), .out_payload(out_payload),
    .out_len(out_len), .out_lanes(out_lanes)
  );

  typedef struct {
    logic [1:0]  pfx;
    logic [63:0] pay;
    logic [6:0]  len;
    logic [63:0] lanes;
    int          acc;
  } exp_t;

  exp_t q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  int   cyc    = 0;
  bit   lat_on = 1'b1;
  bit   bp_mode = 1'b0;
  bit   done   = 1'b0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] p);
    case (p)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  // Reference model written from the requirements
  function automatic exp_t model(input logic [63:0] w);
    exp_t e;
    logic [7:0] by [8];
    for (int b = 0; b < 8; b++) by[b] = w[8*b +: 8];
    if (w == 64'd0) begin
      e.pfx = 2'b00; e.pay = 64'd0; e.len = 7'd0;
    end else if (by[7] == 0 && by[6] == 0 && by[5] == 0 && by[4] == 0) begin
      e.pfx = 2'b01; e.pay = {w[31:0], 32'd0}; e.len = 7'd32;
    end else if (by[7] == 0 && by[6] == 0 && by[3] == 0 && by[2] == 0) begin
      e.pfx = 2'b10; e.pay = {by[5], by[4], by[1], by[0], 32'd0}; e.len = 7'd32;
    end else begin
      e.pfx = 2'b11; e.pay = w; e.len = 7'd64;
    end
    e.lanes = {by[4], by[3], by[5], by[2], by[6], by[1], by[7], by[0]};
    e.acc = 0;
    return e;
  endfunction

  task automatic send(input logic [63:0] w);
    exp_t e;
    e = model(w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    e.acc = cyc + 1;
    q.push_back(e);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // Monitor: drives out_ready, checks held outputs and compares results
  initial begin : monitor
    logic [15:0] lf = 16'hACE1;
    bit          held = 1'b0;
    logic [1:0]  h_pfx;
    logic [63:0] h_pay, h_lanes;
    logic [6:0]  h_len;
    exp_t        e;
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      if (bp_mode) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        out_ready = lf[0] & lf[2];
      end else begin
        out_ready = 1'b1;
      end
      if (rst_n) begin
        if (held) begin
          // R9: stalled output keeps its value
          chk(out_valid == 1'b1, "R9 valid held", {63'd0, out_valid}, 64'd1);
          chk(out_prefix == h_pfx && out_len == h_len, "R9 prefix/len held",
              {55'd0, out_len, out_prefix}, {55'd0, h_len, h_pfx});
          chk(out_payload == h_pay, "R9 payload held", out_payload, h_pay);
          chk(out_lanes == h_lanes, "R9 lanes held", out_lanes, h_lanes);
        end
        held = out_valid && !out_ready;
        h_pfx = out_prefix; h_pay = out_payload; h_len = out_len; h_lanes = out_lanes;
        if (out_valid && out_ready) begin
          if (q.size() == 0) begin
            chk(1'b0, "R8 unexpected output", out_payload, 64'd0);
          end else begin
            e = q.pop_front();
            chk(out_prefix == e.pfx, {tag_of(e.pfx), " R6 prefix"}, {62'd0, out_prefix}, {62'd0, e.pfx});
            chk(out_payload == e.pay, {tag_of(e.pfx), " payload"}, out_payload, e.pay);
            chk(out_len == e.len, {tag_of(e.pfx), " length"}, {57'd0, out_len}, {57'd0, e.len});
            chk(out_lanes == e.lanes, "R7 lanes", out_lanes, e.lanes);
            if (lat_on)
              chk(cyc == e.acc + 1, "R8 latency", 64'(cyc), 64'(e.acc + 1));
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired with %0d results outstanding", q.size());
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] r = 64'h0123_4567_89AB_CDEF;
    logic [63:0] w;
    in_valid = 1'b0;
    in_word  = 64'd0;
    rst_n    = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R10 out_valid after reset", {63'd0, out_valid}, 64'd0);
    chk(in_ready == 1'b1, "R10 in_ready after reset", {63'd0, in_ready}, 64'd1);

    // Phase 1: directed words, no backpressure, latency checked
    send(64'd0);                          // R2
    send(64'd1 << 0);                     // R1 bit 0 -> R3
    send(64'd1 << 23);                    // R1 byte 2 -> R3
    send(64'd1 << 39);                    // R1 byte 4 -> R4
    send(64'd1 << 48);                    // R1 byte 6 -> R5
    send(64'd1 << 63);                    // R1 byte 7 -> R5
    send(64'h0000_0000_1234_5678);        // R3
    send(64'h0000_ABCD_0000_1234);        // R4
    send(64'h0000_0000_0000_00FF);        // R6: both 01 and 10 match
    send(64'h0011_0000_0000_0000);        // R5
    send(64'h8000_0000_0000_0001);        // R5
    send(64'h0102_0304_0506_0708);        // R7 lane order
    send(64'h0000_0200_0000_0000);        // R4 byte 5 only
    // back-to-back throughput under no stall (R8)
    for (int i = 0; i < 20; i++) begin
      r = {r[62:0], r[63] ^ r[62] ^ r[60] ^ r[59]};
      send(r);
    end
    wait (q.size() == 0);
    @(negedge clk);

    // Phase 2: mixed patterns with random backpressure (R8, R9)
    lat_on  = 1'b0;
    bp_mode = 1'b1;
    for (int i = 0; i < 300; i++) begin
      r = {r[62:0], r[63] ^ r[62] ^ r[60] ^ r[59]};
      case (r[2:0])
        3'd0:    w = 64'd0;
        3'd1:    w = {32'd0, r[40:9]};
        3'd2:    w = r & 64'h0000_FFFF_0000_FFFF;
        3'd3:    w = r & 64'h0000_0000_0000_FF00;
        default: w = r;
      endcase
      send(w);
    end
    wait (q.size() == 0);
    repeat (4) @(negedge clk);
    chk(q.size() == 0 && out_valid == 1'b0, "R8 pipeline drained",
        {63'd0, out_valid}, 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule